// File: doc/BRIEF.md
# Framebuffer Select and Blanking Controller

This block holds the video mode register and the framebuffer control register of a display add-on. A bus decoder hands it byte writes. A host vertical-blank status comes in as an input. The block drives three things:
- which of two DRAM framebuffers the host side currently sees,
- a blanking status bit (VBLK),
- a one-cycle palette-dirty pulse for the palette logic.

Two small state machines carry the behaviour.

The blanking machine has two states:
- `BLK_DISPLAY`: display enabled, mode bits [1:0] non-zero. Here VBLK follows the host vertical-blank input one cycle later.
- `BLK_FORCED`: forced blanking, mode bits [1:0] zero. Here VBLK is frozen.

A mode write moves the machine between the two states. Transition `enter_forced` goes from `BLK_DISPLAY` to `BLK_FORCED`, and `leave_forced` goes back. Each of these transitions resamples the host vertical-blank input into VBLK.

The swap machine has two states, `SW_IDLE` and `SW_ARMED`:
- A framebuffer request that differs from the current select bit (FS) takes effect at once if VBLK is set. This is transition `swap_now`, and it stays in `SW_IDLE`.
- If VBLK is clear, the request moves the machine to `SW_ARMED` (transition `arm`).
- From `SW_ARMED`, the machine applies the request on the next rising edge of VBLK (transition `swap_on_vblank`).
- A request equal to FS returns the machine to `SW_IDLE` (transition `cancel`).

The host-visible buffer is always the inverse of FS.

Top module: `fbsel_blank_ctrl`

## Requirements
- R1: After reset, `disp_sel` is 1, `vblk` is 0, `pal_dirty` is 0, the mode register reads 0x8000 (palette-mode upper byte 0x80, low byte 0), and the control register reads 0x0000. With mode bits [1:0] zero, the block starts in forced blanking.
- R2: A byte write to offset 0x1 replaces bits [7:0] of the mode register and leaves bits [15:8] unchanged. The mode register reads back at offset 0x0 from the cycle after the write.
- R3: A mode write that changes whether bits [1:0] are zero loads `vblk` with the value of `host_vblank` in the write cycle.
- R4: In display state, `vblk` equals `host_vblank` delayed by one clock. In forced blanking, `vblk` holds its value until a mode write.
- R5: A mode write that changes bit 7 (priority) gives `pal_dirty` = 1 for exactly the next cycle. A mode write that keeps bit 7 gives no pulse.
- R6: A byte write to offset 0xB uses only bit 0 as the request. If `vblk` is 1 and the request differs from FS, FS toggles at once and `disp_sel` becomes the inverse of the request on the next cycle.
- R7: If the request differs from FS while `vblk` is 0, `disp_sel` is unchanged. FS takes the request one clock after `vblk` next rises.
- R8: The control register reads at offset 0xA as FS in bit 0, the pending request in bit 1, `vblk` in bit 15, and zero in all other bits. Reads of any other offset return 0.
- R9: Byte writes to offsets other than 0x1 and 0xB have no effect on the mode register, the control register or `disp_sel`.
- R10: A request equal to the current FS cancels an armed request, so a later rise of `vblk` does not swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 8 | Write data byte |
| host_vblank | input | 1 | Host vertical-blank status |
| rd_addr | input | 4 | Byte offset of the read (even offsets hold registers) |
| rd_data | output | 16 | Combinational read data |
| disp_sel | output | 1 | Framebuffer currently mapped to the host side |
| vblk | output | 1 | Blanking status bit |
| pal_dirty | output | 1 | One-cycle pulse when the priority bit toggles |

## Verification
Framebuffer requests are applied in three ways:
- with VBLK set, which separates the immediate swap from the deferred one;
- with VBLK clear followed by a host vertical-blank rise, which shows that the armed request waits exactly one clock past the VBLK rise;
- as an arm followed by an equal request, which shows that cancellation stops the later swap.

Mode writes are tried in three kinds:
- some that cross the forced-blanking boundary while the host status disagrees with the held VBLK, which separates resampling from plain tracking;
- some that stay on one side of the boundary;
- some that toggle or keep the priority bit, to tell a pulse from none.

Writes to unused and even offsets confirm that both registers and the select are left alone.

// File: rtl/fbsel_pkg.sv
package fbsel_pkg;

    typedef enum logic {
        BLK_DISPLAY = 1'b0,
        BLK_FORCED  = 1'b1
    } blank_state_t;

    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_ARMED = 1'b1
    } swap_state_t;

endpackage

// File: rtl/fbsel_mode_ctrl.sv
module fbsel_mode_ctrl
    import fbsel_pkg::*;
#(
    parameter int MODE_W          = 16,
    parameter int LO_W            = 8,
    parameter int PRI_BIT         = 7,
    parameter logic [MODE_W-LO_W-1:0] MODE_HI_RST = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [LO_W-1:0]   wr_byte,
    input  logic              host_vblank,
    output logic [MODE_W-1:0] mode_q,
    output logic              vblk,
    output logic              pal_dirty,
    output logic              forced_blank
);

    blank_state_t      state_q, state_d;
    logic [LO_W-1:0]   mode_lo_q;
    logic              blank_req;
    logic              blank_edge;
    logic              pri_flip;

    // Decode of the incoming write
    always_comb begin
        blank_req  = (wr_byte[1:0] == 2'b00);
        blank_edge = mode_wr && (blank_req != (state_q == BLK_FORCED));
        pri_flip   = mode_wr && (wr_byte[PRI_BIT] != mode_lo_q[PRI_BIT]);
    end

    // Next-state logic: enter_forced / leave_forced
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_DISPLAY: if (mode_wr && blank_req)  state_d = BLK_FORCED;
            BLK_FORCED:  if (mode_wr && !blank_req) state_d = BLK_DISPLAY;
            default:     state_d = BLK_FORCED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BLK_FORCED;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lo_q <= '0;
            vblk      <= 1'b0;
            pal_dirty <= 1'b0;
        end else begin
            pal_dirty <= pri_flip;
            if (mode_wr) mode_lo_q <= wr_byte;
            if (blank_edge)                  vblk <= host_vblank;
            else if (state_q == BLK_DISPLAY) vblk <= host_vblank;
        end
    end

    assign mode_q       = {MODE_HI_RST, mode_lo_q};
    assign forced_blank = (state_q == BLK_FORCED);

endmodule

// File: rtl/fbsel_swap_ctrl.sv
module fbsel_swap_ctrl
    import fbsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_wr,
    input  logic req_bit,
    input  logic vblk,
    output logic fs,
    output logic pend
);

    swap_state_t state_q, state_d;
    logic        vblk_d;
    logic        vblk_rise;
    logic        fs_d;
    logic        pend_d;

    assign vblk_rise = vblk && !vblk_d;

    // Next-state: swap_now, arm, cancel, swap_on_vblank
    always_comb begin
        state_d = state_q;
        fs_d    = fs;
        pend_d  = pend;
        if (fb_wr) begin
            pend_d = req_bit;
            if (req_bit != fs) begin
                if (vblk) begin
                    fs_d    = ~fs;
                    state_d = SW_IDLE;
                end else begin
                    state_d = SW_ARMED;
                end
            end else begin
                state_d = SW_IDLE;
            end
        end else begin
            unique case (state_q)
                SW_IDLE:  state_d = SW_IDLE;
                SW_ARMED: begin
                    if (vblk_rise) begin
                        fs_d    = pend;
                        state_d = SW_IDLE;
                    end
                end
                default:  state_d = SW_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs     <= 1'b0;
            pend   <= 1'b0;
            vblk_d <= 1'b0;
        end else begin
            fs     <= fs_d;
            pend   <= pend_d;
            vblk_d <= vblk;
        end
    end

endmodule

// File: rtl/fbsel_read_mux.sv
module fbsel_read_mux #(
    parameter int ADDR_W      = 4,
    parameter int MODE_W      = 16,
    parameter logic [ADDR_W-1:0] MODE_RD_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] CTRL_RD_OFS = 4'hA
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              fs,
    input  logic              pend,
    input  logic              vblk,
    output logic [MODE_W-1:0] rd_data
);

    localparam int VBLK_BIT = MODE_W - 1;

    logic [MODE_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[0]        = fs;
        ctrl_word[1]        = pend;
        ctrl_word[VBLK_BIT] = vblk;
    end

    always_comb begin
        if (rd_addr == MODE_RD_OFS)      rd_data = mode_q;
        else if (rd_addr == CTRL_RD_OFS) rd_data = ctrl_word;
        else                             rd_data = '0;
    end

endmodule

// File: rtl/fbsel_blank_ctrl.sv
module fbsel_blank_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int MODE_W  = 16,
    parameter int LO_W    = 8,
    parameter int PRI_BIT = 7,
    parameter logic [MODE_W-LO_W-1:0] MODE_HI_RST = 8'h80,
    parameter logic [ADDR_W-1:0] MODE_WR_OFS = 4'h1,
    parameter logic [ADDR_W-1:0] CTRL_WR_OFS = 4'hB,
    parameter logic [ADDR_W-1:0] MODE_RD_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] CTRL_RD_OFS = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LO_W-1:0]   wr_data,
    input  logic              host_vblank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [MODE_W-1:0] rd_data,
    output logic              disp_sel,
    output logic              vblk,
    output logic              pal_dirty
);

    logic              mode_wr;
    logic              fb_wr;
    logic [MODE_W-1:0] mode_q;
    logic              forced_blank;
    logic              fs;
    logic              pend;

    assign mode_wr = wr_en && (wr_addr == MODE_WR_OFS);
    assign fb_wr   = wr_en && (wr_addr == CTRL_WR_OFS);

    fbsel_mode_ctrl #(
        .MODE_W      (MODE_W),
        .LO_W        (LO_W),
        .PRI_BIT     (PRI_BIT),
        .MODE_HI_RST (MODE_HI_RST)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .wr_byte      (wr_data),
        .host_vblank  (host_vblank),
        .mode_q       (mode_q),
        .vblk         (vblk),
        .pal_dirty    (pal_dirty),
        .forced_blank (forced_blank)
    );

    fbsel_swap_ctrl u_swap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_wr   (fb_wr),
        .req_bit (wr_data[0]),
        .vblk    (vblk),
        .fs      (fs),
        .pend    (pend)
    );

    fbsel_read_mux #(
        .ADDR_W      (ADDR_W),
        .MODE_W      (MODE_W),
        .MODE_RD_OFS (MODE_RD_OFS),
        .CTRL_RD_OFS (CTRL_RD_OFS)
    ) u_rd (
        .rd_addr (rd_addr),
        .mode_q  (mode_q),
        .fs      (fs),
        .pend    (pend),
        .vblk    (vblk),
        .rd_data (rd_data)
    );

    assign disp_sel = ~fs;

endmodule

// File: rtl/fbsel_blank_chk.sv
module fbsel_blank_chk #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] MODE_WR_OFS = 4'h1,
    parameter logic [ADDR_W-1:0] CTRL_WR_OFS = 4'hB
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              req_bit,
    input logic              vblk,
    input logic              disp_sel,
    input logic              pal_dirty,
    input logic              forced_blank
);

    logic mode_wr_c;
    logic fb_wr_c;

    assign mode_wr_c = wr_en && (wr_addr == MODE_WR_OFS);
    assign fb_wr_c   = wr_en && (wr_addr == CTRL_WR_OFS);

    assert_vblk_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_blank && !mode_wr_c) |=> $stable(vblk));

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pal_dirty |-> $past(mode_wr_c));

    assert_swap_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_wr_c && vblk && (req_bit == disp_sel)) |=> (disp_sel != $past(disp_sel)));

    assert_swap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_sel) |-> ($past(fb_wr_c) || ($past(vblk) && !$past(vblk, 2))));

endmodule

bind fbsel_blank_ctrl fbsel_blank_chk #(
    .ADDR_W      (ADDR_W),
    .MODE_WR_OFS (MODE_WR_OFS),
    .CTRL_WR_OFS (CTRL_WR_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .req_bit      (wr_data[0]),
    .vblk         (vblk),
    .disp_sel     (disp_sel),
    .pal_dirty    (pal_dirty),
    .forced_blank (forced_blank)
);

// File: tb/fbsel_blank_ctrl_test.sv
`timescale 1ns/1ps
module fbsel_blank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        host_vblank = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        disp_sel;
    logic        vblk;
    logic        pal_dirty;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fbsel_blank_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .host_vblank (host_vblank),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .disp_sel    (disp_sel),
        .vblk        (vblk),
        .pal_dirty   (pal_dirty)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 disp_sel", {15'b0, disp_sel}, 16'h1);
        check("R1 vblk", {15'b0, vblk}, 16'h0);
        check("R1 pal_dirty", {15'b0, pal_dirty}, 16'h0);
        rd(4'h0, v); check("R1 mode", v, 16'h8000);
        rd(4'hA, v); check("R1/R8 ctrl", v, 16'h0000);
    endtask

    task automatic t_mode_write();
        logic [15:0] v;
        host_vblank = 1'b0;
        wr(4'h1, 8'h01);
        rd(4'h0, v); check("R2 mode low byte", v, 16'h8001);
        rd(4'h6, v); check("R8 unused read", v, 16'h0000);
    endtask

    task automatic t_forced();
        host_vblank = 1'b1;
        idle(2);
        check("R4 follow in display", {15'b0, vblk}, 16'h1);
        wr(4'h1, 8'h00);
        check("R3 enter samples", {15'b0, vblk}, 16'h1);
        host_vblank = 1'b0;
        idle(3);
        check("R4 hold in forced", {15'b0, vblk}, 16'h1);
        wr(4'h1, 8'h02);
        check("R3 leave samples", {15'b0, vblk}, 16'h0);
    endtask

    task automatic t_priority();
        wr(4'h1, 8'h82);
        check("R5 pulse", {15'b0, pal_dirty}, 16'h1);
        idle(1);
        check("R5 one cycle", {15'b0, pal_dirty}, 16'h0);
        wr(4'h1, 8'h83);
        check("R5 no toggle", {15'b0, pal_dirty}, 16'h0);
    endtask

    task automatic t_swap_now();
        logic [15:0] v;
        host_vblank = 1'b1;
        idle(2);
        wr(4'hB, 8'h01);
        check("R6 swap now", {15'b0, disp_sel}, 16'h0);
        rd(4'hA, v); check("R8 ctrl fields", v, 16'h8003);
        wr(4'hB, 8'hFE);
        check("R6 bit0 only", {15'b0, disp_sel}, 16'h1);
        rd(4'hA, v); check("R8 ctrl back", v, 16'h8000);
    endtask

    task automatic t_swap_deferred();
        logic [15:0] v;
        host_vblank = 1'b0;
        idle(2);
        wr(4'hB, 8'h01);
        check("R7 held off", {15'b0, disp_sel}, 16'h1);
        rd(4'hA, v); check("R7 pending", v, 16'h0002);
        host_vblank = 1'b1;
        idle(1);
        check("R7 not before rise+1", {15'b0, disp_sel}, 16'h1);
        idle(1);
        check("R7 applied", {15'b0, disp_sel}, 16'h0);
    endtask

    task automatic t_cancel();
        logic [15:0] v;
        host_vblank = 1'b0;
        idle(2);
        wr(4'hB, 8'h00);
        wr(4'hB, 8'h01);
        host_vblank = 1'b1;
        idle(3);
        check("R10 cancelled", {15'b0, disp_sel}, 16'h0);
        rd(4'hA, v); check("R10 ctrl", v, 16'h8003);
    endtask

    task automatic t_ignored();
        logic [15:0] v;
        wr(4'h0, 8'hFF);
        wr(4'hA, 8'hFE);
        wr(4'h5, 8'h00);
        wr(4'h3, 8'h00);
        rd(4'h0, v); check("R9 mode kept", v, 16'h8083);
        rd(4'hA, v); check("R9 ctrl kept", v, 16'h8003);
        check("R9 disp_sel kept", {15'b0, disp_sel}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_write();
        t_forced();
        t_priority();
        t_swap_now();
        t_swap_deferred();
        t_cancel();
        t_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule